// File: doc/BRIEF.md
# I2C Register Target with Relocatable Address

This block is an I2C target that sits on a two-wire control bus and gives a host access to a small byte-wide register space. SCL and SDA arrive as raw pad inputs. The block samples them with the system clock, resynchronises and filters them, and then decodes START, repeated START and STOP conditions. It matches a 7-bit device address and answers with an acknowledge by enabling its SDA pull-down. A write transaction first sets an internal register pointer and then stores data bytes. A read transaction returns bytes from the pointer. In both directions the pointer moves forward byte by byte, so one transaction can cover a run of consecutive registers.

The register space has five kinds of entry:
- A fixed identification byte.
- A control byte that holds the per-channel interrupt enables.
- A status byte with per-channel completion flags and a power-up flag. The status byte clears itself when it is read.
- A relocation byte that lets software move the device to another bus address.
- A general storage bank for downstream configuration.

Each accepted store to a writable register also appears as a one-cycle strobe with its address and data, so neighbouring logic can pick the value up. An active-low interrupt output stays asserted while any enabled flag is set. Writing a key value to register 00h returns every register to its default.

Top module: `i2c_reg_target`

## Requirements
- R1: After reset the block acknowledges device address 45h and leaves SDA released (no acknowledge) for any other address.
- R2: Register 77h holds a select bit in bit 7 and an alternative address in bits 6:0. While the select bit is 1, only the alternative address is acknowledged. While it is 0, 45h is used. A new value applies from the next transaction onward, and the register reads back as written.
- R3: In a write transaction, the first byte after the address sets the pointer. Each following byte is stored at the pointer and then the pointer increments. Every store to a writable register produces exactly one single-cycle wr_stb_o carrying that register's address and data.
- R4: A read transaction (R/W bit = 1), entered by a repeated START or by STOP then START after the pointer is set, returns the byte at the pointer. The pointer advances only when the host acknowledges a byte. A host NACK ends the read and leaves the pointer on the last byte sent.
- R5: Bytes travel MSB first, and each byte is followed by one acknowledge bit. A START or STOP seen in the middle of a byte aborts the transfer: the partial byte is discarded, nothing is stored, and the SDA pull-down is released.
- R6: Writing 55h to register 00h returns every register to its default: storage bank reads 00h, control 00h, relocation 45h, status 10h. Writing any other value to 00h has no effect.
- R7: Reading register 00h returns 33h.
- R8: Register 02h reads back with the flag of channel i in bit 5+i and the power-up flag in bit 4. A pulse on done_i[i] sets the flag of channel i. Reset sets the power-up flag. Reading the register clears every flag, and writes to it are ignored.
- R9: irq_n_o is low while the power-up flag is set, or while any channel flag is set together with its enable. The enable for channel i is bit 5+i of register 01h.
- R10: Registers outside 00h–02h, 30h–3Fh and 77h read as 00h. Writes to them are ignored and raise no strobe.
- R11: SCL and SDA pass through a two-stage synchroniser and a three-sample majority filter, so a pulse one clock long on either line has no effect on a transfer.
- R12: Registers 30h–3Fh are a 16-byte storage bank. It can be written and read back in a single burst in either direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Raw bus clock from the pad |
| sda_i | input | 1 | Raw bus data from the pad (wired-AND level) |
| done_i | input | 3 | Per-channel completion pulses that set the status flags |
| sda_pull_o | output | 1 | Enables the SDA pull-down (acknowledge or read data 0) |
| wr_stb_o | output | 1 | One-cycle strobe for each store to a writable register |
| wr_addr_o | output | 8 | Register address that goes with wr_stb_o |
| wr_data_o | output | 8 | Data byte that goes with wr_stb_o |
| irq_n_o | output | 1 | Active-low interrupt request |

## Verification
The assertions rely on a bus host that changes SDA only while SCL is low, except when it deliberately forms a START or STOP. They also rely on SCL high and low phases lasting well beyond the filter delay. Under those conditions the pull-down can only move while the filtered clock is low, and strobes stay a single cycle long. The bench host holds every SCL phase for twelve clocks and keeps data changes on the low phase. It breaks that rule only in two places: single-clock glitches that the filter is meant to reject, and a STOP placed mid-byte to exercise the abort path.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

  typedef enum logic [2:0] {
    BS_IDLE,
    BS_ADDR,
    BS_ACK_A,
    BS_RX,
    BS_ACK_W,
    BS_TX,
    BS_ACK_R
  } bus_st_t;

  localparam logic [7:0] REG_ID    = 8'h00;
  localparam logic [7:0] REG_CTRL  = 8'h01;
  localparam logic [7:0] REG_STAT  = 8'h02;
  localparam logic [7:0] REG_RELOC = 8'h77;
  localparam logic [7:0] RESET_KEY = 8'h55;

endpackage

// File: rtl/i2c_tgt_filter.sv
module i2c_tgt_filter #(
  parameter int SYNC_LEN = 2,
  parameter int FILT_LEN = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic raw_i,
  output logic clean_o
);
  localparam int HALF = FILT_LEN / 2;

  logic [SYNC_LEN-1:0] sync_q;
  logic [FILT_LEN-1:0] hist_q;
  logic                clean_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q  <= '1;
      hist_q  <= '1;
      clean_q <= 1'b1;
    end else begin
      sync_q  <= {sync_q[SYNC_LEN-2:0], raw_i};
      hist_q  <= {hist_q[FILT_LEN-2:0], sync_q[SYNC_LEN-1]};
      clean_q <= ($countones(hist_q) > HALF);
    end
  end

  assign clean_o = clean_q;
endmodule

// File: rtl/i2c_tgt_bus.sv
module i2c_tgt_bus
  import i2c_tgt_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       scl_f,
  input  logic       sda_f,
  input  logic [6:0] dev_addr_i,
  input  logic [7:0] rd_data_i,
  output logic [7:0] rd_addr_o,
  output logic       rd_stb_o,
  output logic [7:0] rd_done_addr_o,
  output logic       wr_stb_o,
  output logic [7:0] wr_addr_o,
  output logic [7:0] wr_data_o,
  output logic       sda_pull_o,
  output logic       stop_o
);
  logic       scl_q, sda_q;
  bus_st_t    st;
  logic [3:0] bitcnt;
  logic [7:0] sh, tx, ptr;
  logic       rw_q, first_q, mack_q, pull_q;

  logic scl_rise, scl_fall, start_c, stop_c, byte_full;
  assign scl_rise  = scl_f & ~scl_q;
  assign scl_fall  = ~scl_f & scl_q;
  assign start_c   = scl_f & scl_q & sda_q & ~sda_f;
  assign stop_c    = scl_f & scl_q & ~sda_q & sda_f;
  assign byte_full = (bitcnt == 4'd8);

  // after a host ACK the next byte comes from the following register
  assign rd_addr_o = (st == BS_ACK_R) ? ptr + 8'd1 : ptr;

  always_ff @(posedge clk) begin
    scl_q    <= scl_f;
    sda_q    <= sda_f;
    wr_stb_o <= 1'b0;
    rd_stb_o <= 1'b0;
    if (rst) begin
      scl_q <= 1'b1; sda_q <= 1'b1;
      st <= BS_IDLE; bitcnt <= '0; sh <= '0; tx <= '0; ptr <= '0;
      rw_q <= 1'b0; first_q <= 1'b0; mack_q <= 1'b0; pull_q <= 1'b0;
      wr_addr_o <= '0; wr_data_o <= '0; rd_done_addr_o <= '0;
    end else if (start_c) begin
      st <= BS_ADDR; bitcnt <= '0; pull_q <= 1'b0;
    end else if (stop_c) begin
      st <= BS_IDLE; pull_q <= 1'b0;
    end else begin
      unique case (st)
        BS_IDLE: ;
        BS_ADDR, BS_RX: begin
          if (scl_rise && !byte_full) begin
            sh     <= {sh[6:0], sda_f};
            bitcnt <= bitcnt + 4'd1;
          end else if (scl_fall && byte_full) begin
            bitcnt <= '0;
            if (st == BS_ADDR) begin
              if (sh[7:1] == dev_addr_i) begin
                rw_q <= sh[0]; first_q <= 1'b1; pull_q <= 1'b1; st <= BS_ACK_A;
              end else begin
                st <= BS_IDLE;
              end
            end else begin
              pull_q <= 1'b1; st <= BS_ACK_W;
              if (first_q) begin
                ptr <= sh; first_q <= 1'b0;
              end else begin
                wr_stb_o <= 1'b1; wr_addr_o <= ptr; wr_data_o <= sh;
                ptr <= ptr + 8'd1;
              end
            end
          end
        end
        BS_ACK_A: if (scl_fall) begin
          bitcnt <= '0;
          if (rw_q) begin
            tx <= rd_data_i; pull_q <= ~rd_data_i[7];
            rd_stb_o <= 1'b1; rd_done_addr_o <= rd_addr_o; st <= BS_TX;
          end else begin
            pull_q <= 1'b0; st <= BS_RX;
          end
        end
        BS_ACK_W: if (scl_fall) begin
          pull_q <= 1'b0; st <= BS_RX;
        end
        BS_TX: begin
          if (scl_rise) bitcnt <= bitcnt + 4'd1;
          else if (scl_fall) begin
            if (byte_full) begin
              pull_q <= 1'b0; st <= BS_ACK_R;
            end else begin
              tx <= {tx[6:0], 1'b0}; pull_q <= ~tx[6];
            end
          end
        end
        BS_ACK_R: begin
          if (scl_rise) mack_q <= ~sda_f;
          else if (scl_fall) begin
            if (mack_q) begin
              ptr <= rd_addr_o; tx <= rd_data_i; pull_q <= ~rd_data_i[7];
              rd_stb_o <= 1'b1; rd_done_addr_o <= rd_addr_o;
              bitcnt <= '0; st <= BS_TX;
            end else begin
              st <= BS_IDLE;
            end
          end
        end
        default: st <= BS_IDLE;
      endcase
    end
  end

  assign sda_pull_o = pull_q;
  assign stop_o     = stop_c;
endmodule

// File: rtl/i2c_tgt_regs.sv
module i2c_tgt_regs
  import i2c_tgt_pkg::*;
#(
  parameter logic [6:0] DEF_ADDR   = 7'h45,
  parameter logic [7:0] ID_VAL     = 8'h33,
  parameter logic [7:0] BANK_BASE  = 8'h30,
  parameter int         BANK_DEPTH = 16,
  parameter int         NCH        = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           wr_stb_i,
  input  logic [7:0]     wr_addr_i,
  input  logic [7:0]     wr_data_i,
  input  logic           rd_stb_i,
  input  logic [7:0]     rd_done_addr_i,
  input  logic [7:0]     rd_addr_i,
  input  logic [NCH-1:0] done_i,
  output logic [7:0]     rd_data_o,
  output logic [6:0]     dev_addr_o,
  output logic           irq_n_o,
  output logic           stb_o,
  output logic [7:0]     stb_addr_o,
  output logic [7:0]     stb_data_o
);
  localparam int IDX_W = (BANK_DEPTH > 1) ? $clog2(BANK_DEPTH) : 1;
  localparam logic [8:0] BANK_END = {1'b0, BANK_BASE} + 9'(BANK_DEPTH);

  logic [7:0]            mem [BANK_DEPTH];
  logic [BANK_DEPTH-1:0] vld_q;
  logic [7:0]            ctrl_q, reloc_q;
  logic [NCH-1:0]        flag_q;
  logic                  pu_q;

  function automatic logic in_bank(input logic [7:0] a);
    return (a >= BANK_BASE) && ({1'b0, a} < BANK_END);
  endfunction

  logic             soft_hit, wr_bank, writable, clr;
  logic [IDX_W-1:0] widx, ridx;
  assign soft_hit = wr_stb_i && (wr_addr_i == REG_ID) && (wr_data_i == RESET_KEY);
  assign wr_bank  = wr_stb_i && in_bank(wr_addr_i);
  assign writable = in_bank(wr_addr_i) || (wr_addr_i == REG_CTRL) || (wr_addr_i == REG_RELOC);
  assign clr      = rd_stb_i && (rd_done_addr_i == REG_STAT);
  assign widx     = IDX_W'(wr_addr_i - BANK_BASE);
  assign ridx     = IDX_W'(rd_addr_i - BANK_BASE);

  // storage without reset; a valid vector provides the cleared view
  always_ff @(posedge clk) begin
    if (wr_bank) mem[widx] <= wr_data_i;
  end

  always_ff @(posedge clk) begin
    if (rst || soft_hit) begin
      vld_q   <= '0;
      ctrl_q  <= '0;
      reloc_q <= {1'b0, DEF_ADDR};
      flag_q  <= '0;
      pu_q    <= 1'b1;
    end else begin
      if (wr_bank) vld_q[widx] <= 1'b1;
      if (wr_stb_i && wr_addr_i == REG_CTRL)  ctrl_q  <= wr_data_i;
      if (wr_stb_i && wr_addr_i == REG_RELOC) reloc_q <= wr_data_i;
      for (int i = 0; i < NCH; i++)
        flag_q[i] <= done_i[i] | (flag_q[i] & ~clr);
      pu_q <= pu_q & ~clr;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_n_o <= 1'b0;
      stb_o   <= 1'b0;
    end else begin
      irq_n_o <= ~(pu_q | (|(flag_q & ctrl_q[5 +: NCH])));
      stb_o   <= wr_stb_i && writable;
    end
    stb_addr_o <= wr_addr_i;
    stb_data_o <= wr_data_i;
  end

  logic [7:0] stat_vec;
  always_comb begin
    stat_vec    = '0;
    stat_vec[4] = pu_q;
    for (int i = 0; i < NCH; i++) stat_vec[5+i] = flag_q[i];
  end

  always_comb begin
    rd_data_o = '0;
    if (in_bank(rd_addr_i)) rd_data_o = vld_q[ridx] ? mem[ridx] : 8'h00;
    else if (rd_addr_i == REG_ID)    rd_data_o = ID_VAL;
    else if (rd_addr_i == REG_CTRL)  rd_data_o = ctrl_q;
    else if (rd_addr_i == REG_STAT)  rd_data_o = stat_vec;
    else if (rd_addr_i == REG_RELOC) rd_data_o = reloc_q;
  end

  assign dev_addr_o = reloc_q[7] ? reloc_q[6:0] : DEF_ADDR;
endmodule

// File: rtl/i2c_reg_target.sv
module i2c_reg_target #(
  parameter logic [6:0] DEF_ADDR   = 7'h45,
  parameter logic [7:0] ID_VAL     = 8'h33,
  parameter logic [7:0] BANK_BASE  = 8'h30,
  parameter int         BANK_DEPTH = 16,
  parameter int         NCH        = 3,
  parameter int         SYNC_LEN   = 2,
  parameter int         FILT_LEN   = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           scl_i,
  input  logic           sda_i,
  input  logic [NCH-1:0] done_i,
  output logic           sda_pull_o,
  output logic           wr_stb_o,
  output logic [7:0]     wr_addr_o,
  output logic [7:0]     wr_data_o,
  output logic           irq_n_o
);
  logic       scl_f, sda_f;
  logic [6:0] dev_addr;
  logic [7:0] rd_addr, rd_data, rd_done_addr, bus_wr_addr, bus_wr_data;
  logic       bus_rd_stb, bus_wr_stb, bus_stop;

  i2c_tgt_filter #(.SYNC_LEN(SYNC_LEN), .FILT_LEN(FILT_LEN)) u_fscl (
    .clk(clk), .rst(rst), .raw_i(scl_i), .clean_o(scl_f));
  i2c_tgt_filter #(.SYNC_LEN(SYNC_LEN), .FILT_LEN(FILT_LEN)) u_fsda (
    .clk(clk), .rst(rst), .raw_i(sda_i), .clean_o(sda_f));

  i2c_tgt_bus u_bus (
    .clk(clk), .rst(rst), .scl_f(scl_f), .sda_f(sda_f),
    .dev_addr_i(dev_addr), .rd_data_i(rd_data),
    .rd_addr_o(rd_addr), .rd_stb_o(bus_rd_stb), .rd_done_addr_o(rd_done_addr),
    .wr_stb_o(bus_wr_stb), .wr_addr_o(bus_wr_addr), .wr_data_o(bus_wr_data),
    .sda_pull_o(sda_pull_o), .stop_o(bus_stop));

  i2c_tgt_regs #(
    .DEF_ADDR(DEF_ADDR), .ID_VAL(ID_VAL), .BANK_BASE(BANK_BASE),
    .BANK_DEPTH(BANK_DEPTH), .NCH(NCH)
  ) u_regs (
    .clk(clk), .rst(rst),
    .wr_stb_i(bus_wr_stb), .wr_addr_i(bus_wr_addr), .wr_data_i(bus_wr_data),
    .rd_stb_i(bus_rd_stb), .rd_done_addr_i(rd_done_addr), .rd_addr_i(rd_addr),
    .done_i(done_i), .rd_data_o(rd_data), .dev_addr_o(dev_addr),
    .irq_n_o(irq_n_o), .stb_o(wr_stb_o), .stb_addr_o(wr_addr_o), .stb_data_o(wr_data_o));
endmodule

// File: rtl/i2c_reg_target_chk.sv
module i2c_reg_target_chk #(
  parameter logic [7:0] BANK_BASE  = 8'h30,
  parameter int         BANK_DEPTH = 16
) (
  input logic       clk,
  input logic       rst,
  input logic       scl_f,
  input logic       sda_pull,
  input logic       bus_wr_stb,
  input logic       bus_rd_stb,
  input logic       bus_stop,
  input logic       wr_stb,
  input logic [7:0] wr_addr,
  input logic       irq_n
);
  localparam logic [8:0] BANK_END = {1'b0, BANK_BASE} + 9'(BANK_DEPTH);

  // R5: pull-down only moves while the filtered clock is low
  a_r5_pull_steady_scl_high: assert property (@(posedge clk) disable iff (rst)
    ($past(scl_f) && scl_f) |-> $stable(sda_pull));

  // R5: a STOP always leaves SDA released
  a_r5_stop_releases: assert property (@(posedge clk) disable iff (rst)
    bus_stop |=> !sda_pull);

  // R3: each store gives a strobe of one cycle
  a_r3_single_strobe: assert property (@(posedge clk) disable iff (rst)
    wr_stb |=> !wr_stb);

  // R10: strobes only name writable registers
  a_r10_strobe_mapped: assert property (@(posedge clk) disable iff (rst)
    wr_stb |-> ((wr_addr == 8'h01) || (wr_addr == 8'h77) ||
                ((wr_addr >= BANK_BASE) && ({1'b0, wr_addr} < BANK_END))));

  // R9: interrupt is released only after a bus read or write
  a_r9_irq_release_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_n) |-> $past(bus_wr_stb || bus_rd_stb, 2));
endmodule

bind i2c_reg_target i2c_reg_target_chk #(.BANK_BASE(BANK_BASE), .BANK_DEPTH(BANK_DEPTH)) u_chk (
  .clk(clk), .rst(rst), .scl_f(scl_f), .sda_pull(sda_pull_o),
  .bus_wr_stb(bus_wr_stb), .bus_rd_stb(bus_rd_stb), .bus_stop(bus_stop),
  .wr_stb(wr_stb_o), .wr_addr(wr_addr_o), .irq_n(irq_n_o));

// File: tb/sim_i2c_reg_target.sv
module sim_i2c_reg_target;
  localparam int QTR = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic [2:0] done = '0;
  logic sda_pull, wr_stb, irq_n;
  logic [7:0] wr_addr, wr_data;
  wire sda_bus = sda_m & ~sda_pull;

  int nvec = 0;
  int nerr = 0;
  int stb_cnt = 0;
  logic [7:0] stb_a [64];
  logic [7:0] stb_d [64];
  bit finished = 1'b0;

  always #10 clk = ~clk;

  i2c_reg_target u0 (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_bus), .done_i(done),
    .sda_pull_o(sda_pull), .wr_stb_o(wr_stb), .wr_addr_o(wr_addr),
    .wr_data_o(wr_data), .irq_n_o(irq_n));

  always @(negedge clk) if (!rst && wr_stb) begin
    stb_a[stb_cnt % 64] = wr_addr;
    stb_d[stb_cnt % 64] = wr_data;
    stb_cnt++;
  end

  function automatic logic [7:0] pat(input int i);
    return 8'(i * 29 + 7) ^ 8'h5A;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic qw(); repeat (QTR) @(negedge clk); endtask

  task automatic bus_start();
    sda_m = 1'b1; qw(); scl_m = 1'b1; qw(); sda_m = 1'b0; qw(); scl_m = 1'b0; qw();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; qw(); scl_m = 1'b1; qw(); sda_m = 1'b1; qw(); qw();
  endtask

  task automatic put_bit(input logic b, input logic gsc, input logic gsd);
    sda_m = b; qw(); scl_m = 1'b1; qw();
    if (gsc) begin scl_m = 1'b0; @(negedge clk); scl_m = 1'b1; end
    if (gsd) begin sda_m = ~b; @(negedge clk); sda_m = b; end
    qw(); scl_m = 1'b0;
  endtask

  task automatic get_bit(output logic b);
    sda_m = 1'b1; qw(); scl_m = 1'b1; qw(); b = sda_bus; qw(); scl_m = 1'b0;
  endtask

  task automatic put_byte(input logic [7:0] b, input logic gl, output logic nk);
    for (int i = 7; i >= 0; i--) put_bit(b[i], gl && (i == 4), gl && (i == 2));
    get_bit(nk);
  endtask

  task automatic get_byte(input logic last, output logic [7:0] v);
    logic b;
    for (int i = 0; i < 8; i++) begin get_bit(b); v = {v[6:0], b}; end
    put_bit(last, 1'b0, 1'b0);
  endtask

  task automatic wr_one(input logic [6:0] dev, input logic [7:0] ra, input logic [7:0] dat,
                        output logic nk);
    logic n1, n2, n3;
    bus_start(); put_byte({dev, 1'b0}, 1'b0, n1); put_byte(ra, 1'b0, n2);
    put_byte(dat, 1'b0, n3); bus_stop(); nk = n1 | n2 | n3;
  endtask

  task automatic rd_prep(input logic [6:0] dev, input logic [7:0] ra, input logic via_stop,
                         output logic nk);
    logic n1, n2, n3;
    bus_start(); put_byte({dev, 1'b0}, 1'b0, n1); put_byte(ra, 1'b0, n2);
    if (via_stop) bus_stop();
    bus_start(); put_byte({dev, 1'b1}, 1'b0, n3); nk = n1 | n2 | n3;
  endtask

  task automatic rd_one(input logic [6:0] dev, input logic [7:0] ra, input logic via_stop,
                        output logic [7:0] v);
    logic nk;
    rd_prep(dev, ra, via_stop, nk); get_byte(1'b1, v); bus_stop();
  endtask

  task automatic probe(input logic [6:0] dev, output logic nk);
    bus_start(); put_byte({dev, 1'b0}, 1'b0, nk); bus_stop();
  endtask

  task automatic pulse_done(input int ch);
    done[ch] = 1'b1; @(negedge clk); done[ch] = 1'b0; repeat (6) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    if (!finished) begin
      nerr++;
      $display("FAIL watchdog: run did not end, actual hang expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end

  initial begin : stim
    logic nk;
    logic [7:0] v;
    int base;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (8) @(negedge clk);

    // reset state
    chk("R8 power-up irq", irq_n, 0);
    chk("R1 released at reset", sda_pull, 0);

    // R7 identification, R1 default address
    rd_prep(7'h45, 8'h00, 1'b0, nk);
    chk("R1 default address acked", nk, 0);
    get_byte(1'b1, v); bus_stop();
    chk("R7 id read", v, 8'h33);
    probe(7'h46, nk);
    chk("R1 other address nack", nk, 1);
    probe(7'h05, nk);
    chk("R1 other address nack 05h", nk, 1);

    // R8 status read clears and R9 releases irq
    rd_one(7'h45, 8'h02, 1'b1, v);
    chk("R8 power-up flag", v, 8'h10);
    repeat (6) @(negedge clk);
    chk("R9 irq released after read", irq_n, 1);
    rd_one(7'h45, 8'h02, 1'b0, v);
    chk("R8 cleared by read", v, 8'h00);

    // R3, R12 burst write of the whole bank
    base = stb_cnt;
    bus_start(); put_byte({7'h45, 1'b0}, 1'b0, nk); put_byte(8'h30, 1'b0, nk);
    for (int i = 0; i < 16; i++) put_byte(pat(i), 1'b0, nk);
    bus_stop();
    chk("R3 strobe count burst", stb_cnt - base, 16);
    for (int i = 0; i < 16; i++) begin
      chk("R3 strobe address", stb_a[(base + i) % 64], 8'h30 + 8'(i));
      chk("R3 strobe data", stb_d[(base + i) % 64], pat(i));
    end

    // R4, R12 burst read with repeated start
    rd_prep(7'h45, 8'h30, 1'b0, nk);
    for (int i = 0; i < 16; i++) begin
      get_byte(i == 15, v);
      chk("R12 bank burst read", v, pat(i));
    end
    bus_stop();

    // R4 pointer holds after NACK
    rd_one(7'h45, 8'h33, 1'b1, v);
    chk("R4 single read", v, pat(3));
    bus_start(); put_byte({7'h45, 1'b1}, 1'b0, nk); get_byte(1'b1, v); bus_stop();
    chk("R4 pointer kept after nack", v, pat(3));

    // R10 unmapped, R8 status write ignored
    base = stb_cnt;
    wr_one(7'h45, 8'h10, 8'hAB, nk);
    chk("R10 no strobe unmapped", stb_cnt - base, 0);
    rd_one(7'h45, 8'h10, 1'b0, v);
    chk("R10 unmapped reads zero", v, 8'h00);
    wr_one(7'h45, 8'h02, 8'hFF, nk);
    rd_one(7'h45, 8'h02, 1'b0, v);
    chk("R8 write to status ignored", v, 8'h00);

    // R9 channel enables
    wr_one(7'h45, 8'h01, 8'h40, nk);
    pulse_done(0);
    chk("R9 disabled channel no irq", irq_n, 1);
    pulse_done(1);
    chk("R9 enabled channel irq", irq_n, 0);
    rd_one(7'h45, 8'h02, 1'b0, v);
    chk("R8 channel flags", v, 8'h60);
    repeat (6) @(negedge clk);
    chk("R9 irq released", irq_n, 1);
    rd_one(7'h45, 8'h01, 1'b0, v);
    chk("R9 control readback", v, 8'h40);
    pulse_done(2);
    rd_one(7'h45, 8'h02, 1'b0, v);
    chk("R8 channel 2 flag bit 7", v, 8'h80);

    // R11 glitches on both lines during a byte
    bus_start(); put_byte({7'h45, 1'b0}, 1'b0, nk); put_byte(8'h31, 1'b0, nk);
    put_byte(8'hC3, 1'b1, nk); bus_stop();
    rd_one(7'h45, 8'h31, 1'b0, v);
    chk("R11 glitch rejected", v, 8'hC3);

    // R5 abort by STOP mid-byte
    base = stb_cnt;
    bus_start(); put_byte({7'h45, 1'b0}, 1'b0, nk); put_byte(8'h32, 1'b0, nk);
    put_bit(1'b1, 1'b0, 1'b0); put_bit(1'b0, 1'b0, 1'b0);
    put_bit(1'b0, 1'b0, 1'b0); put_bit(1'b1, 1'b0, 1'b0);
    bus_stop();
    chk("R5 aborted byte no strobe", stb_cnt - base, 0);
    rd_one(7'h45, 8'h32, 1'b0, v);
    chk("R5 aborted byte not stored", v, pat(2));

    // R2 relocation
    wr_one(7'h45, 8'h77, 8'hA2, nk);
    probe(7'h45, nk);
    chk("R2 old address nack", nk, 1);
    probe(7'h22, nk);
    chk("R2 new address ack", nk, 0);
    rd_one(7'h22, 8'h77, 1'b1, v);
    chk("R2 relocation readback", v, 8'hA2);
    wr_one(7'h22, 8'h77, 8'h22, nk);
    probe(7'h22, nk);
    chk("R2 select clear nack", nk, 1);
    probe(7'h45, nk);
    chk("R2 select clear default ack", nk, 0);
    wr_one(7'h45, 8'h77, 8'hA2, nk);

    // R6 non-key value then key
    wr_one(7'h22, 8'h00, 8'hAA, nk);
    rd_one(7'h22, 8'h30, 1'b0, v);
    chk("R6 non-key ignored", v, pat(0));
    wr_one(7'h22, 8'h00, 8'h55, nk);
    repeat (6) @(negedge clk);
    chk("R6 power-up irq again", irq_n, 0);
    probe(7'h45, nk);
    chk("R6 address back to default", nk, 0);
    rd_one(7'h45, 8'h30, 1'b0, v);
    chk("R6 bank cleared", v, 8'h00);
    rd_one(7'h45, 8'h77, 1'b0, v);
    chk("R6 relocation default", v, 8'h45);
    rd_one(7'h45, 8'h01, 1'b0, v);
    chk("R6 control default", v, 8'h00);
    rd_one(7'h45, 8'h02, 1'b0, v);
    chk("R6 status default", v, 8'h10);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule